// File: doc/BRIEF.md
# Multichannel DAC Serial Register Interface

This block is the digital front end of a multichannel digital-to-analog converter. A host writes 24-bit frames over a four-wire serial link. Each frame carries a 2-bit command, a 6-bit address and a 16-bit payload. The block keeps a register file for every channel: a primary code, an alternate code, an offset trim and a gain trim. It also holds one control word and one coarse offset register per reference group. The primary codes, the trims and the coarse offset that each channel inherits from its reference group come out as flat vectors for the converter core. Control bit 0 drives the global powerdown output.

Registers are read with a two-frame exchange. A request frame names a register class and an address. The register's value is captured when that frame ends. It is shifted out on the serial output during the next frame, while that frame's own command runs in the usual way. The serial pins are sampled in the system clock domain. The system clock must run at least four times faster than the serial clock, and the pins must already be synchronous to it.

The channel count, the group size, the number of references and the code resolution are parameters. At lower resolutions, codes are kept left-justified and the unused low bits read back as zero.

Top module: `mdac_spi_regs`

## Requirements
- R1: Bits are taken MSB first on each rising serial clock while select is low. When select rises, the frame is executed only if exactly 24 bits arrived since select fell. A frame of 23 or 25 bits has no effect on any register or on the readback.
- R2: After reset, the primary and alternate codes and the channel offsets hold 0x8000. Gains hold 0xFFFF. Group offsets hold 0x2000. The control word is 0 and powerdown is low.
- R3: Command 3 (bits [23:22]) to address 8+n (bits [21:16]) stores payload [15:0] into channel n. It goes to the primary code when control bit 2 is 0 and to the alternate code when it is 1. Only the primary code drives the channel's code output.
- R4: Command 2 writes the channel offset and command 1 writes the channel gain, with the same address rule as R3.
- R5: Command 0 to address 1 writes the control word. Its bit 0 drives the powerdown output, which changes only when a control write is executed.
- R6: Command 0 to address 2+k, for k below the number of references, stores payload bits [13:0] into group offset k.
- R7: Channel n takes the group offset with index floor(n / group size). Channels whose index would reach or pass the last reference share the last reference's register.
- R8: Command 0 to address 5 is a readback request with the class in payload [15:13] and the target address in [12:7]. The value captured when that frame ends is shifted out MSB first on the serial output during the next frame, as 8 zero bits followed by 16 data bits. Any later frame returns zero.
- R9: Readback class 0 returns the primary code, 1 the alternate code, 2 the offset and 3 the gain of the addressed channel. Class 4 returns the control word at address 1 and group offset k, zero-extended, at address 2+k.
- R10: A write to an address with no register behind it changes nothing. A readback of such an address, or of class 5 to 7, returns zero.
- R11: A frame that starts one clock after the previous frame's select rise still returns the value that the previous frame requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out (readback) |
| pd | output | 1 | Global powerdown (control bit 0) |
| code_o | output | N_CH*16 | Primary code of each channel |
| gain_o | output | N_CH*16 | Gain trim of each channel |
| ofs_o | output | N_CH*16 | Offset trim of each channel |
| ref_ofs_o | output | N_CH*14 | Group offset seen by each channel |

## Verification
Three things fall on the same clock edges here: executing a readback request at one select rise, loading the shift-out register at the next select fall, and clearing the pending value at that same fall. The bench forces this by holding select high for only one clock between frames. The returned frame must carry the requested value while its own write still lands, and the frame after it must return zero. A second overlap is a request whose return frame carries a write. The bench checks that the write becomes visible on the outputs in the cycle after select rises, and a behavioural model compares every output vector on every clock.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

    localparam int FRAME_W  = 24;
    localparam int ADDR_W   = 6;
    localparam int WORD_W   = 16;
    localparam int GOFS_W   = 14;
    localparam int CH_BASE  = 8;

    typedef enum logic [1:0] {
        CMD_SPECIAL = 2'd0,
        CMD_GAIN    = 2'd1,
        CMD_OFFSET  = 2'd2,
        CMD_CODE    = 2'd3
    } cmd_e;

    localparam logic [2:0] RB_PRIMARY = 3'd0;
    localparam logic [2:0] RB_ALT     = 3'd1;
    localparam logic [2:0] RB_OFFSET  = 3'd2;
    localparam logic [2:0] RB_GAIN    = 3'd3;
    localparam logic [2:0] RB_SPECIAL = 3'd4;

    localparam logic [ADDR_W-1:0] SF_CTRL  = 6'd1;
    localparam logic [ADDR_W-1:0] SF_GOFS0 = 6'd2;
    localparam logic [ADDR_W-1:0] SF_RBREQ = 6'd5;

    localparam int CTRL_PD_BIT   = 0;
    localparam int CTRL_BSEL_BIT = 2;

    typedef struct packed {
        cmd_e                cmd;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   payload;
    } frame_t;

    typedef struct packed {
        logic wr_primary;
        logic wr_alt;
        logic wr_offset;
        logic wr_gain;
        logic wr_ctrl;
        logic wr_gofs;
        logic rb_req;
    } strobe_t;

    function automatic int unsigned ref_index(int unsigned ch, int unsigned grp,
                                              int unsigned nref);
        int unsigned idx;
        idx = ch / grp;
        if (idx >= nref) idx = nref - 1;
        return idx;
    endfunction

endpackage

// File: rtl/mdac_shift.sv
module mdac_shift
    import mdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [WORD_W-1:0] tx_word,
    output frame_t            frame,
    output logic              commit,
    output logic              frame_start,
    output logic              miso
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic               sclk_q, cs_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] rx_q, tx_q;
    logic               s_rise, s_fall, c_fall, c_rise;

    always_comb begin
        s_rise = sclk & ~sclk_q;
        s_fall = ~sclk & sclk_q;
        c_fall = ~cs_n & cs_q;
        c_rise = cs_n & ~cs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (c_fall)
                cnt_q <= s_rise ? CNT_W'(1) : '0;
            else if (!cs_n && s_rise && cnt_q != CNT_SAT)
                cnt_q <= cnt_q + 1'b1;
            if (!cs_n && s_rise)
                rx_q <= {rx_q[FRAME_W-2:0], mosi};
            if (c_fall)
                tx_q <= {{(FRAME_W-WORD_W){1'b0}}, tx_word};
            else if (!cs_n && s_fall)
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign frame       = frame_t'(rx_q);
    assign commit      = c_rise && (cnt_q == CNT_FULL);
    assign frame_start = c_fall;
    assign miso        = tx_q[FRAME_W-1];

    p_count_restart_r1: assert property (@(posedge clk) disable iff (rst)
        c_fall |=> (cnt_q <= CNT_W'(1)));
    p_idle_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_q && cs_n) |=> $stable(cnt_q));
    p_tx_head_zero_r8: assert property (@(posedge clk) disable iff (rst)
        c_fall |=> (tx_q[FRAME_W-1:WORD_W] == '0));

endmodule

// File: rtl/mdac_decode.sv
module mdac_decode
    import mdac_pkg::*;
#(
    parameter int N_CH  = 24,
    parameter int N_REF = 2,
    parameter int CHW   = $clog2(N_CH),
    parameter int RW    = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic            commit,
    input  frame_t          frame,
    input  logic            bsel,
    output strobe_t         stb,
    output logic [CHW-1:0]  ch,
    output logic [RW-1:0]   gsel
);
    localparam logic [ADDR_W:0] CH_LO = (ADDR_W+1)'(CH_BASE);
    localparam logic [ADDR_W:0] CH_HI = (ADDR_W+1)'(CH_BASE + N_CH);
    localparam logic [ADDR_W:0] GO_LO = (ADDR_W+1)'(SF_GOFS0);
    localparam logic [ADDR_W:0] GO_HI = (ADDR_W+1)'(int'(SF_GOFS0) + N_REF);

    logic [ADDR_W:0] a7;
    logic            ch_hit, go_hit, sf;

    always_comb begin
        a7     = {1'b0, frame.addr};
        ch_hit = (a7 >= CH_LO) && (a7 < CH_HI);
        go_hit = (a7 >= GO_LO) && (a7 < GO_HI);
        sf     = commit && (frame.cmd == CMD_SPECIAL);
        ch     = CHW'(frame.addr - ADDR_W'(CH_BASE));
        gsel   = RW'(frame.addr - SF_GOFS0);

        stb            = '0;
        stb.wr_primary = commit && ch_hit && (frame.cmd == CMD_CODE) && !bsel;
        stb.wr_alt     = commit && ch_hit && (frame.cmd == CMD_CODE) && bsel;
        stb.wr_offset  = commit && ch_hit && (frame.cmd == CMD_OFFSET);
        stb.wr_gain    = commit && ch_hit && (frame.cmd == CMD_GAIN);
        stb.wr_ctrl    = sf && (frame.addr == SF_CTRL);
        stb.wr_gofs    = sf && go_hit;
        stb.rb_req     = sf && (frame.addr == SF_RBREQ);
    end

endmodule

// File: rtl/mdac_regs.sv
module mdac_regs
    import mdac_pkg::*;
#(
    parameter int N_CH      = 24,
    parameter int GRP       = 8,
    parameter int N_REF     = 2,
    parameter int CODE_BITS = 16,
    parameter int CHW       = $clog2(N_CH),
    parameter int RW        = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  strobe_t                  stb,
    input  logic [CHW-1:0]           ch,
    input  logic [RW-1:0]            gsel,
    input  logic [WORD_W-1:0]        wdata,
    input  logic                     frame_start,
    output logic [WORD_W-1:0]        ctrl,
    output logic [WORD_W-1:0]        pend,
    output logic [N_CH*WORD_W-1:0]   code_o,
    output logic [N_CH*WORD_W-1:0]   gain_o,
    output logic [N_CH*WORD_W-1:0]   ofs_o,
    output logic [N_CH*GOFS_W-1:0]   ref_ofs_o
);
    localparam logic [WORD_W-1:0] CMASK    = 16'hFFFF << (WORD_W - CODE_BITS);
    localparam logic [WORD_W-1:0] MID      = 16'h8000 & CMASK;
    localparam logic [GOFS_W-1:0] GOFS_MID = 14'h2000;
    localparam logic [ADDR_W:0] CH_LO = (ADDR_W+1)'(CH_BASE);
    localparam logic [ADDR_W:0] CH_HI = (ADDR_W+1)'(CH_BASE + N_CH);
    localparam logic [ADDR_W:0] GO_LO = (ADDR_W+1)'(SF_GOFS0);
    localparam logic [ADDR_W:0] GO_HI = (ADDR_W+1)'(int'(SF_GOFS0) + N_REF);

    logic [WORD_W-1:0] pri_q [N_CH];
    logic [WORD_W-1:0] alt_q [N_CH];
    logic [WORD_W-1:0] off_q [N_CH];
    logic [WORD_W-1:0] gn_q  [N_CH];
    logic [GOFS_W-1:0] gofs_q[N_REF];
    logic [WORD_W-1:0] ctrl_q, pend_q, rb_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CH; c++) begin
                pri_q[c] <= MID;
                alt_q[c] <= MID;
                off_q[c] <= MID;
                gn_q[c]  <= CMASK;
            end
            for (int g = 0; g < N_REF; g++) gofs_q[g] <= GOFS_MID;
            ctrl_q <= '0;
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                if (ch == CHW'(c)) begin
                    if (stb.wr_primary) pri_q[c] <= wdata & CMASK;
                    if (stb.wr_alt)     alt_q[c] <= wdata & CMASK;
                    if (stb.wr_offset)  off_q[c] <= wdata & CMASK;
                    if (stb.wr_gain)    gn_q[c]  <= wdata & CMASK;
                end
            end
            for (int g = 0; g < N_REF; g++)
                if (stb.wr_gofs && gsel == RW'(g)) gofs_q[g] <= wdata[GOFS_W-1:0];
            if (stb.wr_ctrl) ctrl_q <= wdata;
        end
    end

    // Readback selector: class in [15:13], target address in [12:7]
    logic [2:0]        rb_cls;
    logic [ADDR_W-1:0] rb_adr;
    logic [ADDR_W:0]   rb_a7;
    logic [CHW-1:0]    rb_ch;
    logic [RW-1:0]     rb_g;
    logic              rb_ch_ok, rb_g_ok;

    always_comb begin
        rb_cls   = wdata[15:13];
        rb_adr   = wdata[12:7];
        rb_a7    = {1'b0, rb_adr};
        rb_ch    = CHW'(rb_adr - ADDR_W'(CH_BASE));
        rb_g     = RW'(rb_adr - SF_GOFS0);
        rb_ch_ok = (rb_a7 >= CH_LO) && (rb_a7 < CH_HI);
        rb_g_ok  = (rb_a7 >= GO_LO) && (rb_a7 < GO_HI);
        rb_val   = '0;
        case (rb_cls)
            RB_PRIMARY: if (rb_ch_ok) rb_val = pri_q[rb_ch];
            RB_ALT:     if (rb_ch_ok) rb_val = alt_q[rb_ch];
            RB_OFFSET:  if (rb_ch_ok) rb_val = off_q[rb_ch];
            RB_GAIN:    if (rb_ch_ok) rb_val = gn_q[rb_ch];
            RB_SPECIAL: begin
                if (rb_adr == SF_CTRL)  rb_val = ctrl_q;
                else if (rb_g_ok)       rb_val = {{(WORD_W-GOFS_W){1'b0}}, gofs_q[rb_g]};
            end
            default: rb_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              pend_q <= '0;
        else if (stb.rb_req)  pend_q <= rb_val;
        else if (frame_start) pend_q <= '0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_out
        localparam int RI = ref_index(c, GRP, N_REF);
        assign code_o[c*WORD_W +: WORD_W]    = pri_q[c];
        assign gain_o[c*WORD_W +: WORD_W]    = gn_q[c];
        assign ofs_o[c*WORD_W +: WORD_W]     = off_q[c];
        assign ref_ofs_o[c*GOFS_W +: GOFS_W] = gofs_q[RI];
    end

    assign ctrl = ctrl_q;
    assign pend = pend_q;

    p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));
    p_pd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !stb.wr_ctrl |=> $stable(ctrl_q[CTRL_PD_BIT]));
    p_pend_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !stb.rb_req) |=> (pend_q == '0));
    p_gofs0_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !stb.wr_gofs |=> $stable(gofs_q[0]));

endmodule

// File: rtl/mdac_spi_regs.sv
module mdac_spi_regs
    import mdac_pkg::*;
#(
    parameter int N_CH      = 24,
    parameter int GRP       = 8,
    parameter int N_REF     = 2,
    parameter int CODE_BITS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    cs_n,
    input  logic                    mosi,
    output logic                    miso,
    output logic                    pd,
    output logic [N_CH*16-1:0]      code_o,
    output logic [N_CH*16-1:0]      gain_o,
    output logic [N_CH*16-1:0]      ofs_o,
    output logic [N_CH*14-1:0]      ref_ofs_o
);
    localparam int CHW = $clog2(N_CH);
    localparam int RW  = (N_REF > 1) ? $clog2(N_REF) : 1;

    frame_t            frame;
    strobe_t           stb;
    logic              commit, frame_start;
    logic [CHW-1:0]    ch;
    logic [RW-1:0]     gsel;
    logic [WORD_W-1:0] ctrl, pend;

    mdac_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .tx_word     (pend),
        .frame       (frame),
        .commit      (commit),
        .frame_start (frame_start),
        .miso        (miso)
    );

    mdac_decode #(.N_CH(N_CH), .N_REF(N_REF), .CHW(CHW), .RW(RW)) u_decode (
        .commit (commit),
        .frame  (frame),
        .bsel   (ctrl[CTRL_BSEL_BIT]),
        .stb    (stb),
        .ch     (ch),
        .gsel   (gsel)
    );

    mdac_regs #(.N_CH(N_CH), .GRP(GRP), .N_REF(N_REF), .CODE_BITS(CODE_BITS),
                .CHW(CHW), .RW(RW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .stb         (stb),
        .ch          (ch),
        .gsel        (gsel),
        .wdata       (frame.payload),
        .frame_start (frame_start),
        .ctrl        (ctrl),
        .pend        (pend),
        .code_o      (code_o),
        .gain_o      (gain_o),
        .ofs_o       (ofs_o),
        .ref_ofs_o   (ref_ofs_o)
    );

    assign pd = ctrl[CTRL_PD_BIT];

endmodule

// File: tb/mdac_spi_regs_bench.sv
module mdac_spi_regs_bench;
    localparam int N_CH = 24;
    localparam int GRP  = 8;
    localparam int NREF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, pd;
    logic [N_CH*16-1:0] code_o, gain_o, ofs_o;
    logic [N_CH*14-1:0] ref_ofs_o;

    always #5 clk = ~clk;

    mdac_spi_regs u_mdac_spi_regs (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .pd(pd), .code_o(code_o), .gain_o(gain_o),
        .ofs_o(ofs_o), .ref_ofs_o(ref_ofs_o)
    );

    int errs = 0, checks = 0;
    bit run = 0, done = 0;

    // behavioural model
    int a_m[N_CH], b_m[N_CH], o_m[N_CH], g_m[N_CH];
    int grp_m[NREF];
    int ctrl_m;

    initial begin
        for (int c = 0; c < N_CH; c++) begin
            a_m[c] = 'h8000; b_m[c] = 'h8000; o_m[c] = 'h8000; g_m[c] = 'hFFFF;
        end
        for (int g = 0; g < NREF; g++) grp_m[g] = 'h2000;
        ctrl_m = 0;
    end

    function automatic void model_commit(logic [23:0] f);
        int cmd, ad, pl;
        cmd = int'(f[23:22]); ad = int'(f[21:16]); pl = int'(f[15:0]);
        if (cmd != 0 && ad >= 8 && ad < 8 + N_CH) begin
            if (cmd == 3) begin
                if (ctrl_m[2]) b_m[ad-8] = pl; else a_m[ad-8] = pl;
            end else if (cmd == 2) o_m[ad-8] = pl;
            else g_m[ad-8] = pl;
        end else if (cmd == 0) begin
            if (ad == 1) ctrl_m = pl;
            else if (ad >= 2 && ad < 2 + NREF) grp_m[ad-2] = pl & 'h3FFF;
        end
    endfunction

    function automatic logic [23:0] mk(int cmd, int ad, int pl);
        return {2'(cmd), 6'(ad), 16'(pl)};
    endfunction

    function automatic logic [23:0] rbq(int cls, int ad);
        return mk(0, 5, {3'(cls), 6'(ad), 7'b0});
    endfunction

    // per-clock comparison of all outputs against the model
    always @(negedge clk) begin
        if (run) begin
            logic [N_CH*16-1:0] ec, eg, eo;
            logic [N_CH*14-1:0] er;
            for (int c = 0; c < N_CH; c++) begin
                int gi;
                gi = c / GRP;
                if (gi > NREF - 1) gi = NREF - 1;
                ec[c*16 +: 16] = 16'(a_m[c]);
                eg[c*16 +: 16] = 16'(g_m[c]);
                eo[c*16 +: 16] = 16'(o_m[c]);
                er[c*14 +: 14] = 14'(grp_m[gi]);
            end
            checks += 5;
            if (pd !== ctrl_m[0]) begin
                errs++; $display("FAIL R5 pd act=%0b exp=%0b", pd, ctrl_m[0]);
            end
            if (code_o !== ec) begin
                errs++; $display("FAIL R3 code_o act=%h exp=%h", code_o, ec);
            end
            if (gain_o !== eg) begin
                errs++; $display("FAIL R4 gain_o act=%h exp=%h", gain_o, eg);
            end
            if (ofs_o !== eo) begin
                errs++; $display("FAIL R4 ofs_o act=%h exp=%h", ofs_o, eo);
            end
            if (ref_ofs_o !== er) begin
                errs++; $display("FAIL R7 ref_ofs_o act=%h exp=%h", ref_ofs_o, er);
            end
        end
    end

    task automatic chk(string tag, logic [23:0] act, logic [15:0] exp);
        checks++;
        if (act !== {8'h00, exp}) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, {8'h00, exp});
        end
    endtask

    // entered and left at posedge+1
    task automatic xfer(logic [23:0] f, int nbits, int gap, output logic [23:0] got);
        if (gap > 0) begin
            repeat (gap) @(posedge clk);
            #1;
        end
        cs_n = 1'b0;
        repeat (2) @(posedge clk);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            #1 sclk = 1'b0;
            mosi = (i < 24) ? f[23-i] : 1'b0;
            repeat (2) @(posedge clk);
            #1 if (i < 24) got[23-i] = miso;
            sclk = 1'b1;
            repeat (2) @(posedge clk);
        end
        #1 sclk = 1'b0;
        repeat (2) @(posedge clk);
        #1 cs_n = 1'b1;
        @(posedge clk);
        #1 if (nbits == 24) model_commit(f);
    endtask

    logic [23:0] r;
    localparam logic [23:0] NOP = 24'h0;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        run = 1;

        // reset values (R2)
        xfer(rbq(1, 8), 24, 2, r);
        xfer(rbq(3, 8), 24, 2, r);  chk("R2 alt code reset", r, 16'h8000);
        xfer(rbq(4, 1), 24, 2, r);  chk("R2 gain reset", r, 16'hFFFF);
        xfer(rbq(2, 9), 24, 2, r);  chk("R2 ctrl reset", r, 16'h0000);
        xfer(rbq(4, 2), 24, 2, r);  chk("R2 offset reset", r, 16'h8000);
        xfer(NOP, 24, 2, r);        chk("R2 group offset reset", r, 16'h2000);

        // primary code writes and readback (R3, R8, R9)
        xfer(mk(3, 8, 'h1234), 24, 2, r);
        xfer(mk(3, 31, 'hABCD), 24, 2, r);
        xfer(rbq(0, 31), 24, 2, r);
        xfer(NOP, 24, 2, r);        chk("R9 primary readback ch23", r, 16'hABCD);
        xfer(NOP, 24, 2, r);        chk("R8 returned only once", r, 16'h0000);

        // gain and offset (R4)
        xfer(mk(1, 13, 'h7FFF), 24, 2, r);
        xfer(mk(2, 13, 'h0102), 24, 2, r);
        xfer(rbq(3, 13), 24, 2, r);
        xfer(rbq(2, 13), 24, 2, r); chk("R4 gain readback", r, 16'h7FFF);
        xfer(NOP, 24, 2, r);        chk("R4 offset readback", r, 16'h0102);

        // control, powerdown, alternate bank (R5, R3)
        xfer(mk(0, 1, 'h0001), 24, 2, r);
        xfer(rbq(4, 1), 24, 2, r);
        xfer(mk(0, 1, 'h0004), 24, 2, r); chk("R5 ctrl readback", r, 16'h0001);
        xfer(mk(3, 11, 'h5555), 24, 2, r);
        xfer(rbq(1, 11), 24, 2, r);
        xfer(rbq(0, 11), 24, 2, r); chk("R3 alt bank write", r, 16'h5555);
        xfer(mk(0, 1, 0), 24, 2, r); chk("R3 primary untouched by alt write", r, 16'h8000);

        // group offsets (R6, R7)
        xfer(mk(0, 2, 'hFFFF), 24, 2, r);
        xfer(mk(0, 3, 'h0123), 24, 2, r);
        xfer(rbq(4, 2), 24, 2, r);
        xfer(rbq(4, 3), 24, 2, r);  chk("R6 group0 14-bit store", r, 16'h3FFF);
        xfer(NOP, 24, 2, r);        chk("R6 group1 store", r, 16'h0123);

        // unused addresses and classes (R10)
        xfer(mk(0, 4, 'h5A5A), 24, 2, r);
        xfer(rbq(4, 4), 24, 2, r);
        xfer(mk(3, 7, 'h1111), 24, 2, r); chk("R10 unused special readback", r, 16'h0000);
        xfer(mk(3, 32, 'h2222), 24, 2, r);
        xfer(rbq(0, 7), 24, 2, r);
        xfer(rbq(6, 8), 24, 2, r);  chk("R10 address 7 readback", r, 16'h0000);
        xfer(rbq(0, 32), 24, 2, r); chk("R10 class 6 readback", r, 16'h0000);
        xfer(NOP, 24, 2, r);        chk("R10 address 32 readback", r, 16'h0000);

        // wrong-length frames (R1)
        xfer(mk(3, 9, 'h0F0F), 23, 2, r);
        xfer(mk(3, 9, 'hF0F0), 25, 2, r);
        xfer(rbq(0, 9), 24, 2, r);
        xfer(NOP, 24, 2, r);        chk("R1 short and long frames dropped", r, 16'h8000);
        xfer(rbq(3, 13), 23, 2, r);
        xfer(NOP, 24, 2, r);        chk("R1 short request dropped", r, 16'h0000);

        // back-to-back frames, one clock of select high (R11)
        xfer(rbq(3, 13), 24, 2, r);
        xfer(mk(3, 10, 'h4444), 24, 0, r); chk("R11 tight gap readback", r, 16'h7FFF);
        xfer(rbq(0, 10), 24, 0, r);
        xfer(NOP, 24, 0, r);        chk("R11 write during return frame", r, 16'h4444);
        xfer(NOP, 24, 0, r);        chk("R8 cleared after tight gap", r, 16'h0000);

        repeat (4) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule